// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Bank

This block gives one processor core a small register window for inter-processor interrupts. A sticky 32-bit pending word collects interrupt requests through two write-only ports: one ORs bits in and one knocks bits out. A 32-bit enable word qualifies the pending bits, and one registered level interrupt line goes to the core. Eight 32-bit mailbox words let other cores leave data next to the interrupt.

The interrupt line is not a continuous function of pending and enable. It is re-evaluated only when the set or clear port is written, and the raise and drop conditions differ. The block drives the raise when any pending bit is also enabled after a set. It drives the drop only when the pending word becomes zero after a clear while the enable word is nonzero.

A local write to the send-command offset is not stored. It leaves the block as a one-cycle strobe carrying the written word, and a separate send engine picks it up. Only the low 8 address bits are decoded, so the window repeats through the upper address space.

Top module: `ipi_regbank`

## Requirements
- R1: After synchronous reset the pending word, the enable word, every mailbox word, `irq_o`, `err_o` and `send_stb_o` are all zero.
- R2: Only `addr_i[7:0]` selects a register, so an address that differs only above bit 7 reaches the same register.
- R3: Reads return data on `rd_data_o` one cycle after `rd_en_i`. Offset 0x00 returns the pending word and offset 0x04 returns the enable word. The set port (0x08), the clear port (0x0C) and the send offset (0x40) read as zero.
- R4: A write to offset 0x00 leaves the pending word and `irq_o` unchanged.
- R5: A write to offset 0x08 ORs the data into the pending word. If the new pending word ANDed with enable is nonzero, `irq_o` is 1 from the next cycle; otherwise `irq_o` keeps its value.
- R6: A write to offset 0x0C clears the pending bits that are set in the data. `irq_o` goes to 0 in the next cycle only if the new pending word is zero and the enable word is nonzero; otherwise it keeps its value.
- R7: A write to offset 0x04 replaces the enable word and never changes `irq_o`.
- R8: Mailbox word k (k = 0..7) sits at offset 0x20 + 4*k and reads back the last word written there.
- R9: An access to any other offset, including an offset in the mailbox range that is not word-aligned, reads as zero and changes no state. It drives `err_o` high for exactly the following cycle.
- R10: A write to offset 0x40 drives `send_stb_o` high for exactly the following cycle with the written word on `send_data_o`. It changes no other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Register byte address; only bits 7:0 are decoded |
| wr_en_i | input | 1 | Write enable for one cycle |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read enable for one cycle |
| rd_data_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered level interrupt to the core |
| err_o | output | 1 | One-cycle pulse after an access to an undecoded offset |
| send_stb_o | output | 1 | One-cycle strobe after a send-command write |
| send_data_o | output | DATA_W | Word written with the send command |

## Verification
The bench builds the block with its defaults: a 16-bit address, 32-bit data and eight mailbox words. With a 16-bit address, copies of the window above offset 0xFF can be reached, so aliasing is exercised through the enable register and a mailbox word. With eight mailbox words the whole range from 0x20 to 0x3C is covered, and the bench can probe the first offset past it and a misaligned offset inside it. The directed sequences drive the interrupt line through both asymmetric cases. In one, a clear empties the pending word while enable is zero and the line stays high. In the other, an enable write would change the outcome of a re-evaluation but does not move the line.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam logic [7:0] OFF_STATUS = 8'h00;
  localparam logic [7:0] OFF_ENABLE = 8'h04;
  localparam logic [7:0] OFF_SET    = 8'h08;
  localparam logic [7:0] OFF_CLEAR  = 8'h0C;
  localparam logic [7:0] OFF_MBOX   = 8'h20;
  localparam logic [7:0] OFF_SEND   = 8'h40;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_SET,
    SEL_CLEAR,
    SEL_MBOX,
    SEL_SEND
  } sel_e;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int MBOX_WORDS = 8,
  localparam int IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic [7:0]       off_i,
  output sel_e             sel_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int MBOX_SPAN = MBOX_WORDS * 4;

  logic [7:0] rel;

  always_comb begin
    rel   = off_i - OFF_MBOX;
    sel_o = SEL_NONE;
    idx_o = '0;
    if (off_i == OFF_STATUS)      sel_o = SEL_STATUS;
    else if (off_i == OFF_ENABLE) sel_o = SEL_ENABLE;
    else if (off_i == OFF_SET)    sel_o = SEL_SET;
    else if (off_i == OFF_CLEAR)  sel_o = SEL_CLEAR;
    else if (off_i == OFF_SEND)   sel_o = SEL_SEND;
    else if (off_i >= OFF_MBOX && int'(rel) < MBOX_SPAN && rel[1:0] == 2'b00) begin
      sel_o = SEL_MBOX;
      idx_o = rel[IDX_W+1:2];
    end
  end
endmodule

// File: rtl/ipi_status_ctrl.sv
module ipi_status_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_wr_i,
  input  logic              clr_wr_i,
  input  logic              en_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] pend_o,
  output logic [DATA_W-1:0] enable_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] set_nxt;
  logic [DATA_W-1:0] clr_nxt;

  always_comb begin
    set_nxt = pend_o | wdata_i;
    clr_nxt = pend_o & ~wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o   <= '0;
      enable_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      if (en_wr_i) enable_o <= wdata_i;
      if (set_wr_i) begin
        pend_o <= set_nxt;
        if (|(set_nxt & enable_o)) irq_o <= 1'b1;
      end else if (clr_wr_i) begin
        pend_o <= clr_nxt;
        if (clr_nxt == '0 && enable_o != '0) irq_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
  parameter int DATA_W     = 32,
  parameter int MBOX_WORDS = 8,
  localparam int IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] words [MBOX_WORDS];

  for (genvar k = 0; k < MBOX_WORDS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) words[k] <= '0;
      else if (we_i && int'(idx_i) == k) words[k] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < MBOX_WORDS; k++)
      if (int'(idx_i) == k) rdata_o = words[k];
  end
endmodule

// File: rtl/ipi_regbank.sv
module ipi_regbank
  import ipi_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int MBOX_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              err_o,
  output logic              send_stb_o,
  output logic [DATA_W-1:0] send_data_o
);
  localparam int IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1;

  sel_e              sel;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] pend;
  logic [DATA_W-1:0] enable;
  logic [DATA_W-1:0] mbox_rd;
  logic [DATA_W-1:0] rd_nxt;
  logic              unused_addr_hi;

  if (ADDR_W > 8) begin : g_hi
    assign unused_addr_hi = ^addr_i[ADDR_W-1:8];
  end else begin : g_nohi
    assign unused_addr_hi = 1'b0;
  end

  ipi_decode #(.MBOX_WORDS(MBOX_WORDS)) u_decode (
    .off_i (addr_i[7:0]),
    .sel_o (sel),
    .idx_o (idx)
  );

  ipi_status_ctrl #(.DATA_W(DATA_W)) u_status (
    .clk      (clk),
    .rst      (rst),
    .set_wr_i (wr_en_i && sel == SEL_SET),
    .clr_wr_i (wr_en_i && sel == SEL_CLEAR),
    .en_wr_i  (wr_en_i && sel == SEL_ENABLE),
    .wdata_i  (wr_data_i),
    .pend_o   (pend),
    .enable_o (enable),
    .irq_o    (irq_o)
  );

  ipi_mailbox #(.DATA_W(DATA_W), .MBOX_WORDS(MBOX_WORDS)) u_mbox (
    .clk     (clk),
    .rst     (rst),
    .we_i    (wr_en_i && sel == SEL_MBOX),
    .idx_i   (idx),
    .wdata_i (wr_data_i),
    .rdata_o (mbox_rd)
  );

  always_comb begin
    case (sel)
      SEL_STATUS: rd_nxt = pend;
      SEL_ENABLE: rd_nxt = enable;
      SEL_MBOX:   rd_nxt = mbox_rd;
      default:    rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o   <= '0;
      err_o       <= 1'b0;
      send_stb_o  <= 1'b0;
      send_data_o <= '0;
    end else begin
      if (rd_en_i) rd_data_o <= rd_nxt;
      err_o      <= (rd_en_i || wr_en_i) && sel == SEL_NONE;
      send_stb_o <= wr_en_i && sel == SEL_SEND;
      if (wr_en_i && sel == SEL_SEND) send_data_o <= wr_data_i;
    end
  end
endmodule

// File: rtl/ipi_regbank_chk.sv
module ipi_regbank_chk
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              irq_o,
  input logic              err_o,
  input logic              send_stb_o,
  input logic [DATA_W-1:0] send_data_o
);
  logic [7:0] off;
  assign off = addr_i[7:0];

  p_irq_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(wr_en_i && off == OFF_SET));

  p_irq_fall_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_o) |-> $past(wr_en_i && off == OFF_CLEAR));

  p_enable_keeps_irq_r7: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en_i && off == OFF_ENABLE) |-> irq_o == $past(irq_o));

  p_status_wr_keeps_irq_r4: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en_i && off == OFF_STATUS) |-> $stable(irq_o));

  p_ports_zero_read_r3: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en_i && (off == OFF_SET || off == OFF_CLEAR || off == OFF_SEND)) |-> rd_data_o == '0);

  p_send_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    send_stb_o |-> $past(wr_en_i && off == OFF_SEND) && send_data_o == $past(wr_data_i));

  p_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past((rd_en_i || wr_en_i) && off != OFF_STATUS && off != OFF_ENABLE
                    && off != OFF_SET && off != OFF_CLEAR && off != OFF_SEND));
endmodule

bind ipi_regbank ipi_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .addr_i      (addr_i),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .rd_en_i     (rd_en_i),
  .rd_data_o   (rd_data_o),
  .irq_o       (irq_o),
  .err_o       (err_o),
  .send_stb_o  (send_stb_o),
  .send_data_o (send_data_o)
);

// File: tb/ipi_regbank_bench.sv
module ipi_regbank_bench;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int MBOX_WORDS = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              wr_en_i = 1'b0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic              rd_en_i = 1'b0;
  logic [DATA_W-1:0] rd_data_o;
  logic              irq_o;
  logic              err_o;
  logic              send_stb_o;
  logic [DATA_W-1:0] send_data_o;

  int n_chk = 0;
  int n_bad = 0;
  logic              last_err;
  logic              last_stb;
  logic [DATA_W-1:0] last_sdata;
  logic [DATA_W-1:0] rv;

  always #4 clk = ~clk;

  ipi_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MBOX_WORDS(MBOX_WORDS)) u_ipi_regbank (
    .clk(clk), .rst(rst), .addr_i(addr_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .irq_o(irq_o), .err_o(err_o),
    .send_stb_o(send_stb_o), .send_data_o(send_data_o)
  );

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
    last_err = err_o; last_stb = send_stb_o; last_sdata = send_data_o;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
    d = rd_data_o; last_err = err_o;
  endtask

  task automatic t_reset();
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R1 err", {31'b0, err_o}, 0);
    chk("R1 stb", {31'b0, send_stb_o}, 0);
    rd(16'h0000, rv); chk("R1 status", rv, 0);
    rd(16'h0004, rv); chk("R1 enable", rv, 0);
    for (int k = 0; k < MBOX_WORDS; k++) begin
      rd(16'(16'h20 + 4 * k), rv); chk("R1 mailbox", rv, 0);
    end
  endtask

  task automatic t_set_clear();
    wr(16'h0008, 32'h5);
    chk("R5 no enabled bit keeps irq low", {31'b0, irq_o}, 0);
    rd(16'h0000, rv); chk("R5 set ORs", rv, 32'h5);
    wr(16'h0004, 32'h4);
    chk("R7 enable write leaves irq", {31'b0, irq_o}, 0);
    rd(16'h0004, rv); chk("R3 enable read", rv, 32'h4);
    wr(16'h0008, 32'h0);
    chk("R5 set raises irq", {31'b0, irq_o}, 1);
    rd(16'h0008, rv); chk("R3 set reads zero", rv, 0);
    rd(16'h000C, rv); chk("R3 clear reads zero", rv, 0);
    wr(16'h0000, 32'hFFFF_FFFF);
    rd(16'h0000, rv); chk("R4 status write ignored", rv, 32'h5);
    chk("R4 irq unchanged", {31'b0, irq_o}, 1);
    wr(16'h000C, 32'h4);
    rd(16'h0000, rv); chk("R6 clear bits", rv, 32'h1);
    chk("R6 nonzero status keeps irq", {31'b0, irq_o}, 1);
    wr(16'h000C, 32'h1);
    chk("R6 empty status drops irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_asym();
    wr(16'h0004, 32'h2);
    wr(16'h0008, 32'h2);
    chk("R5 raise", {31'b0, irq_o}, 1);
    wr(16'h0004, 32'h0);
    chk("R7 zero enable keeps irq", {31'b0, irq_o}, 1);
    wr(16'h000C, 32'h2);
    chk("R6 zero enable keeps irq", {31'b0, irq_o}, 1);
    wr(16'h0004, 32'h1);
    chk("R7 enable nonzero still no change", {31'b0, irq_o}, 1);
    wr(16'h000C, 32'h0);
    chk("R6 drop after clear", {31'b0, irq_o}, 0);
  endtask

  task automatic t_mailbox();
    for (int k = 0; k < MBOX_WORDS; k++) wr(16'(16'h20 + 4 * k), 32'hA000_0000 + 32'(k * 17));
    for (int k = 0; k < MBOX_WORDS; k++) begin
      rd(16'(16'h20 + 4 * k), rv); chk("R8 mailbox readback", rv, 32'hA000_0000 + 32'(k * 17));
    end
  endtask

  task automatic t_alias();
    wr(16'h3304, 32'hA5);
    rd(16'h0004, rv); chk("R2 enable alias", rv, 32'hA5);
    wr(16'h0924, 32'h1234_5678);
    rd(16'h0024, rv); chk("R2 mailbox alias", rv, 32'h1234_5678);
    rd(16'hFF24, rv); chk("R2 alias read", rv, 32'h1234_5678);
  endtask

  task automatic t_undecoded();
    rd(16'h0010, rv); chk("R9 read zero", rv, 0);
    chk("R9 err on read", {31'b0, last_err}, 1);
    @(negedge clk); chk("R9 err one cycle", {31'b0, err_o}, 0);
    wr(16'h0060, 32'hDEAD_BEEF);
    chk("R9 err on write past mailbox", {31'b0, last_err}, 1);
    wr(16'h0022, 32'hDEAD_BEEF);
    chk("R9 err on misaligned", {31'b0, last_err}, 1);
    rd(16'h0020, rv); chk("R9 mailbox 0 untouched", rv, 32'hA000_0000);
    chk("R9 no err on valid read", {31'b0, last_err}, 0);
    rd(16'h0000, rv); chk("R9 status untouched", rv, 0);
    rd(16'h0004, rv); chk("R9 enable untouched", rv, 32'hA5);
  endtask

  task automatic t_send();
    wr(16'h0040, 32'hCAFE_0042);
    chk("R10 strobe", {31'b0, last_stb}, 1);
    chk("R10 data", last_sdata, 32'hCAFE_0042);
    chk("R10 no err", {31'b0, last_err}, 0);
    @(negedge clk); chk("R10 strobe one cycle", {31'b0, send_stb_o}, 0);
    rd(16'h0040, rv); chk("R3 send reads zero", rv, 0);
    rd(16'h0000, rv); chk("R10 status untouched", rv, 0);
    rd(16'h0024, rv); chk("R10 mailbox untouched", rv, 32'h1234_5678);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_asym();
    t_mailbox();
    t_alias();
    t_undecoded();
    t_send();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule